// File: doc/BRIEF.md
# Zero-Voltage-Switching Full-Bridge Drive Sequencer

This block generates the four gate commands of a full-bridge power stage that relies on zero-voltage switching. A counter stands in for the timing capacitor of an analog oscillator. Each oscillator period is a programmable ramp-up (charge) phase followed by a programmable deadtime (discharge) phase. One full output switching cycle spans two oscillator periods.

The two upper commands are complementary and run at a fixed 50% duty. They swap state inside the deadtime, a programmable fraction of the deadtime ahead of the next lower turn-on. This gives the resonant transition time to settle before the lower switch closes.

The two lower commands are trailing-edge modulated. They take turns on successive periods, even when a period produces no pulse. Each lower pulse ends when the ramp reaches the duty-compare value or when a terminate request arrives, whichever comes first. Configuration inputs are captured only when a charge phase begins.

Top module: `zvs_bridge_seq`

## Requirements
- R1: While reset is held low, and in the one idle cycle after its release, all four outputs are low. The first charge phase then begins with the left upper output high, and any lower pulse in that period goes to the right lower output.
- R2: One oscillator period lasts charge_len + dead_len clock cycles: charge_len cycles of charge, then dead_len cycles of deadtime. A length of 0 is treated as 1.
- R3: In every charge phase, the active lower output goes high in the first charge cycle and stays high for min(duty_cmp, charge_len) cycles.
- R4: The active lower output alternates every oscillator period (right, left, right, ...), whether or not the previous period produced a pulse.
- R5: A duty_cmp of 0 gives no lower pulse at all, while the upper outputs keep alternating.
- R6: Both lower outputs are low for the whole deadtime, so the per-period duty never exceeds charge_len / (charge_len + dead_len).
- R7: Whenever the block runs, the upper outputs are complementary, and each is high for one oscillator period out of two. They change only inside the deadtime or at the first cycle of a charge phase.
- R8: The upper outputs swap r cycles before the next charge phase begins, where r = floor(min(res_frac, 16) * dead_len / 16) with FRAC_W = 4. A res_frac above 16 acts as 16, so the delay never exceeds the deadtime. An r of 0 means the swap coincides with the start of the charge phase.
- R9: The right lower output is high only while the left upper output is high, and the left lower output is high only while the right upper output is high.
- R10: A term_req sampled high during a charge phase forces both lower outputs low from the next cycle until that charge phase ends. The following period is unaffected.
- R11: duty_cmp, charge_len, dead_len and res_frac are captured only when a charge phase begins. A change during a period takes effect in the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| charge_len | input | CNT_W | Charge (ramp) phase length in cycles |
| dead_len | input | CNT_W | Deadtime phase length in cycles |
| duty_cmp | input | CNT_W | Ramp value at which the lower pulse ends |
| res_frac | input | FRAC_W+1 | Resonant delay as a fraction of the deadtime; full scale is 2^FRAC_W |
| term_req | input | 1 | Request to end the current lower pulse |
| up_l | output | 1 | Upper-left gate command |
| up_r | output | 1 | Upper-right gate command |
| lo_l | output | 1 | Lower-left gate command |
| lo_r | output | 1 | Lower-right gate command |

## Verification
The assertions assume that term_req and all configuration inputs are synchronous to clk and settled at each rising edge. They also assume that reset is held low from time zero until the first edges have passed. The stimulus meets these assumptions by changing every input on the falling edge and by starting each scenario with two reset cycles. Configuration changes land in the middle of a period, so the bench can show that they are deferred to the next period. The terminate request is raised for a single cycle at a known ramp position, so its effect on the current pulse can be checked.

// File: rtl/zvs_seq_pkg.sv
// Shared types for the full-bridge drive sequencer.
package zvs_seq_pkg;

    // Oscillator phase: idle after reset, ramp (charge), then deadtime.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_CHARGE = 2'd1,
        PH_DEAD   = 2'd2
    } osc_phase_t;

endpackage

// File: rtl/zvs_ramp_osc.sv
// Digital sawtooth oscillator. It steps through a charge phase and a deadtime
// phase, and captures the configuration at each charge start.
// Assumes: inputs are synchronous to clk. Zero lengths are raised to one.
module zvs_ramp_osc
    import zvs_seq_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  charge_len,
    input  logic [CNT_W-1:0]  dead_len,
    input  logic [CNT_W-1:0]  duty_cmp,
    input  logic [FRAC_W:0]   res_frac,
    output osc_phase_t        phase,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  dead_q,
    output logic [CNT_W-1:0]  duty_q,
    output logic [CNT_W-1:0]  res_q,
    output logic              period_end
);

    localparam int FULL   = 1 << FRAC_W;
    localparam int PROD_W = CNT_W + FRAC_W + 1;

    logic [CNT_W-1:0]  charge_q;
    logic [CNT_W-1:0]  charge_eff;
    logic [CNT_W-1:0]  dead_eff;
    logic [FRAC_W:0]   frac_eff;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] prod_shift;
    logic [CNT_W-1:0]  res_next;
    logic              load_cfg;
    logic              charge_end;

    // Clamp the lengths and the fraction, and scale the deadtime to get the resonant delay.
    always_comb begin
        charge_eff = (charge_len == '0) ? CNT_W'(1) : charge_len;
        dead_eff   = (dead_len == '0) ? CNT_W'(1) : dead_len;
        frac_eff   = (res_frac > (FRAC_W+1)'(FULL)) ? (FRAC_W+1)'(FULL) : res_frac;
        prod       = PROD_W'(frac_eff) * PROD_W'(dead_eff);
        prod_shift = prod >> FRAC_W;
        res_next   = prod_shift[CNT_W-1:0];
    end

    // Decode the phase boundaries.
    always_comb begin
        charge_end = (phase == PH_CHARGE) && (cnt == charge_q - CNT_W'(1));
        period_end = (phase == PH_DEAD) && (cnt == dead_q - CNT_W'(1));
        load_cfg   = (phase == PH_IDLE) || period_end;
    end

    // Advance the phase and the ramp counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    phase <= PH_CHARGE;
                    cnt   <= '0;
                end
                PH_CHARGE: begin
                    if (charge_end) begin
                        phase <= PH_DEAD;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_DEAD: begin
                    if (period_end) begin
                        phase <= PH_CHARGE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Capture the configuration only as a charge phase begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            charge_q <= CNT_W'(1);
            dead_q   <= CNT_W'(1);
            duty_q   <= '0;
            res_q    <= '0;
        end else if (load_cfg) begin
            charge_q <= charge_eff;
            dead_q   <= dead_eff;
            duty_q   <= duty_cmp;
            res_q    <= res_next;
        end
    end

    // R2
    ramp_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CHARGE) |-> (cnt < charge_q));

    // R2
    dead_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DEAD) |-> (cnt < dead_q));

    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_DEAD) || (phase == PH_CHARGE && cnt != '0))
            |-> ($stable(duty_q) && $stable(res_q) && $stable(dead_q)));

    // R8
    res_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |-> (res_q <= dead_q));

endmodule

// File: rtl/zvs_upper_steer.sv
// Upper bridge steering. It holds the active-pair flag and produces the
// complementary 50% upper commands, swapped early inside the deadtime by the
// resonant delay. Assumes: res_q never exceeds dead_q.
module zvs_upper_steer
    import zvs_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  osc_phase_t        phase,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  dead_q,
    input  logic [CNT_W-1:0]  res_q,
    input  logic              period_end,
    output logic              ul_pair,
    output logic              up_l,
    output logic              up_r
);

    logic in_win;
    logic running;
    logic left_on;

    // Flip the active pair at the end of every oscillator period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ul_pair <= 1'b1;
        end else if (period_end) begin
            ul_pair <= ~ul_pair;
        end
    end

    // Swap the uppers inside the trailing res_q cycles of the deadtime.
    always_comb begin
        in_win  = (phase == PH_DEAD) && (res_q != '0) && (cnt >= dead_q - res_q);
        running = (phase != PH_IDLE);
        left_on = ul_pair ^ in_win;
        up_l    = running && left_on;
        up_r    = running && !left_on;
    end

    // R7
    up_edge_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(up_l) && $past(phase) != PH_IDLE)
            |-> ((phase == PH_DEAD) || (phase == PH_CHARGE && cnt == '0)));

    // R8
    swap_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_CHARGE) && (cnt == '0) && ($past(phase) == PH_DEAD))
            |-> (up_l == ul_pair));

endmodule

// File: rtl/zvs_lower_mod.sv
// Lower bridge modulator. In each charge phase it produces one trailing-edge
// pulse and steers it to the lower switch diagonal to the active upper.
// A terminate request ends the pulse early.
// Assumes: term_req is synchronous to clk.
module zvs_lower_mod
    import zvs_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  osc_phase_t        phase,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  duty_q,
    input  logic              term_req,
    input  logic              ul_pair,
    output logic              lo_l,
    output logic              lo_r
);

    logic kill_q;
    logic pulse;

    // Remember a terminate request until the current charge phase ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kill_q <= 1'b0;
        end else begin
            kill_q <= (phase == PH_CHARGE) && (term_req || kill_q);
        end
    end

    // Compare the ramp with the duty value and steer the pulse to the active side.
    always_comb begin
        pulse = (phase == PH_CHARGE) && (cnt < duty_q) && !kill_q;
        lo_r  = pulse && ul_pair;
        lo_l  = pulse && !ul_pair;
    end

    // R4
    lo_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lo_l && lo_r));

    // R10
    term_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_CHARGE) && term_req) |=> (!lo_l && !lo_r));

    // R5
    zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q == '0) |-> (!lo_l && !lo_r));

endmodule

// File: rtl/zvs_bridge_seq.sv
// Top level of the full-bridge drive sequencer. It ties the oscillator, the
// upper steering and the lower modulator together.
// Assumes: all inputs are synchronous to clk. Reset is synchronous and active low.
module zvs_bridge_seq
    import zvs_seq_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  charge_len,
    input  logic [CNT_W-1:0]  dead_len,
    input  logic [CNT_W-1:0]  duty_cmp,
    input  logic [FRAC_W:0]   res_frac,
    input  logic              term_req,
    output logic              up_l,
    output logic              up_r,
    output logic              lo_l,
    output logic              lo_r
);

    osc_phase_t       phase;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] dead_q;
    logic [CNT_W-1:0] duty_q;
    logic [CNT_W-1:0] res_q;
    logic             period_end;
    logic             ul_pair;

    zvs_ramp_osc #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_osc (
        .clk        (clk),
        .rst_n      (rst_n),
        .charge_len (charge_len),
        .dead_len   (dead_len),
        .duty_cmp   (duty_cmp),
        .res_frac   (res_frac),
        .phase      (phase),
        .cnt        (cnt),
        .dead_q     (dead_q),
        .duty_q     (duty_q),
        .res_q      (res_q),
        .period_end (period_end)
    );

    zvs_upper_steer #(.CNT_W(CNT_W)) u_upper (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .cnt        (cnt),
        .dead_q     (dead_q),
        .res_q      (res_q),
        .period_end (period_end),
        .ul_pair    (ul_pair),
        .up_l       (up_l),
        .up_r       (up_r)
    );

    zvs_lower_mod #(.CNT_W(CNT_W)) u_lower (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .cnt      (cnt),
        .duty_q   (duty_q),
        .term_req (term_req),
        .ul_pair  (ul_pair),
        .lo_l     (lo_l),
        .lo_r     (lo_r)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !(up_l || up_r || lo_l || lo_r));

    // R6
    dead_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DEAD) |-> (!lo_l && !lo_r));

    // R9
    diag_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_r |-> (up_l && !up_r));

    // R9
    diag_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_l |-> (up_r && !up_l));

    // R7
    up_compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |-> (up_l != up_r));

endmodule

// File: tb/sim_zvs_bridge_seq.sv
// Directed bench for the full-bridge drive sequencer.
module sim_zvs_bridge_seq;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;
    localparam int FW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] charge_len = '0;
    logic [CW-1:0] dead_len = '0;
    logic [CW-1:0] duty_cmp = '0;
    logic [FW:0]   res_frac = '0;
    logic          term_req = 1'b0;
    logic          up_l, up_r, lo_l, lo_r;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    zvs_bridge_seq #(.CNT_W(CW), .FRAC_W(FW)) u0 (
        .clk(clk), .rst_n(rst_n), .charge_len(charge_len), .dead_len(dead_len),
        .duty_cmp(duty_cmp), .res_frac(res_frac), .term_req(term_req),
        .up_l(up_l), .up_r(up_r), .lo_l(lo_l), .lo_r(lo_r)
    );

    task automatic check_vec(string req, int idx, logic [3:0] got, logic [3:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s idx %0d: got ulurllr=%b expected %b", req, idx, got, exp);
        end
    endtask

    // One scenario: reset, a trace of n_per periods, term_req pulsed after sample
    // term_idx, and duty_cmp changed after samples c1 and c2.
    task automatic run_case(string req, int c, int d, int duty0, int fr, int n_per,
                            int term_idx, int c1, int d1, int c2, int d2);
        int ce, de, p_len, r, fe;
        charge_len = CW'(c);
        dead_len   = CW'(d);
        duty_cmp   = CW'(duty0);
        res_frac   = (FW+1)'(fr);
        term_req   = 1'b0;
        rst_n      = 1'b0;
        repeat (2) @(negedge clk);
        // R1: quiet while reset is held
        check_vec({req, " R1"}, -1, {up_l, up_r, lo_l, lo_r}, 4'b0000);
        rst_n = 1'b1;
        ce = (c == 0) ? 1 : c;
        de = (d == 0) ? 1 : d;
        p_len = ce + de;
        fe = (fr > 16) ? 16 : fr;
        r = (fe * de) / 16;
        for (int i = 0; i < n_per * p_len; i++) begin
            int p, o, du;
            logic even, lo_on, ul;
            @(negedge clk);
            p = i / p_len;
            o = i % p_len;
            du = duty0;
            if (c1 >= 0 && p * p_len > c1) du = d1;
            if (c2 >= 0 && p * p_len > c2) du = d2;
            even = (p % 2 == 0);
            lo_on = (o < ce) && (o < du);
            if (term_idx >= 0 && (term_idx / p_len) == p && (term_idx % p_len) < ce
                && o > (term_idx % p_len))
                lo_on = 1'b0;
            ul = even ^ ((r > 0) && (o >= p_len - r));
            check_vec(req, i, {up_l, up_r, lo_l, lo_r},
                      {ul, !ul, lo_on && !even, lo_on && even});
            term_req = (i == term_idx);
            if (i == c1) duty_cmp = CW'(d1);
            if (i == c2) duty_cmp = CW'(d2);
        end
        term_req = 1'b0;
    endtask

    // R2 R3 R4 R7 R8 R9: nominal operation with a one-cycle resonant delay
    task automatic t_nominal();
        run_case("R2 R3 R4 R7 R8 R9 nominal", 6, 3, 4, 8, 4, -1, -1, 0, -1, 0);
    endtask

    // R6: duty above the ramp top, pulse limited to the charge phase
    task automatic t_max_duty();
        run_case("R6 R3 max duty", 5, 2, 10, 16, 4, -1, -1, 0, -1, 0);
    endtask

    // R5: zero duty, uppers still alternate
    task automatic t_zero_duty();
        run_case("R5 zero duty", 4, 3, 0, 5, 4, -1, -1, 0, -1, 0);
    endtask

    // R8: fraction above full scale is clamped to the whole deadtime
    task automatic t_res_clamp();
        run_case("R8 clamp", 4, 4, 2, 31, 3, -1, -1, 0, -1, 0);
    endtask

    // R2: zero lengths behave as one cycle each
    task automatic t_zero_len();
        run_case("R2 zero length", 0, 0, 1, 0, 4, -1, -1, 0, -1, 0);
    endtask

    // R10: terminate request at ramp position 2 of the first period
    task automatic t_terminate();
        run_case("R10 terminate", 8, 2, 7, 4, 3, 2, -1, 0, -1, 0);
    endtask

    // R4 R11: skipped pulse keeps alternation, mid-period duty change deferred
    task automatic t_skip_defer();
        run_case("R4 R11 skip and defer", 5, 3, 3, 8, 4, -1, 2, 0, 10, 3);
    endtask

    initial begin
        t_nominal();
        t_max_duty();
        t_zero_duty();
        t_res_clamp();
        t_zero_len();
        t_terminate();
        t_skip_defer();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got no completion, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule